// File: doc/BRIEF.md
# I2C Master Register Front End

This block is the software-facing half of a command-driven I2C master. A processor reaches it through a simple 32-bit register bus with byte offsets. It queues 10-bit command words for a separate bit engine. It collects the bytes that the engine receives, holds the bus timing counts the engine runs on, and raises one level-sensitive interrupt. The SCL/SDA waveforms, bus sampling and the detection of lost arbitration belong to the engine. This block only records what the engine reports.

Software sets the core-enable bit, writes command words (start flag, stop flag, data or address byte), and services the interrupt. A TX-ready or RX-ready condition depends on how full each FIFO is relative to a programmable threshold. NACK, lost arbitration and receive overflow are sticky flags that software clears by writing 1. Clearing the enable bit flushes both queues and the sticky flags, so turning the enable bit off and back on resets the core.

Top module: `i2cm_regfront`

## Requirements
- R1: After reset, control, interrupt enable, the timing counts and both FIFO levels read 0. The interrupt status reads 0x01 (only TX ready is set), `irq` is low and `cmd_valid` is low.
- R2: While enabled, a write to offset 0x00 appends `bus_wdata[9:0]` to the command queue (bit 9 start, bit 8 stop, bits 7:0 byte). `cmd_word` shows the oldest entry with `cmd_valid` high, `cmd_take` removes it, and offset 0x18 reads the occupancy.
- R3: A command write is dropped when the queue already holds FIFO_DEPTH entries and no `cmd_take` occurs in the same cycle.
- R4: While enabled, `rx_push` stores `rx_byte`. A read of offset 0x04 returns the oldest byte in bits 7:0 and removes it. Offset 0x1C reads the occupancy. A read of 0x04 while the queue is empty returns 0 and changes nothing.
- R5: An `rx_push` while the receive queue is full and not being read in the same cycle discards the byte and sets status bit 4 (overflow). A push that coincides with a read of a full queue is stored and sets no flag.
- R6: Offset 0x08 holds bit 0 enable (drives `core_en`), bit 1 fast speed (drives `fast_mode`), bits 3:2 the command threshold code and bits 5:4 the receive threshold code, and reads back as written.
- R7: Status bit 0 (TX ready) is 1 exactly when the command level is less than or equal to its threshold code. Status bit 1 (RX ready) is 1 exactly when the receive level is greater than its threshold code.
- R8: While enabled, a cycle with `eng_nack` high sets status bit 2 and a cycle with `eng_arb` high sets status bit 3. Each bit stays set until it is cleared.
- R9: A write to offset 0x10 clears each of status bits 4:2 whose written bit is 1. Written bits 1:0 have no effect. A flag event in the same cycle as its clear leaves the bit set.
- R10: Offset 0x0C holds a 5-bit interrupt enable with the same layout as the status. `irq` is high exactly when some status bit and its enable bit are both 1.
- R11: While the enable bit is 0, both queues empty, status bits 4:2 clear, and command writes, `rx_push`, `eng_nack` and `eng_arb` are ignored.
- R12: Offsets 0x20, 0x24 and 0x28 store the low CNT_W bits of the write data, drive `scl_low`, `scl_high` and `sda_hold`, and read back.
- R13: Offset 0x14 bit 0 reads `eng_busy`. Offset 0x00 and unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops receive data at 0x04) |
| bus_addr | input | 6 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| cmd_valid | output | 1 | Command queue holds an entry for the engine |
| cmd_word | output | 10 | Oldest command word |
| cmd_take | input | 1 | Engine consumes the oldest command |
| rx_push | input | 1 | Engine delivers a received byte |
| rx_byte | input | 8 | Received byte |
| eng_nack | input | 1 | Engine saw a NACK |
| eng_arb | input | 1 | Engine lost arbitration |
| eng_busy | input | 1 | Engine is active |
| core_en | output | 1 | Core enable |
| fast_mode | output | 1 | Fast bus speed select |
| scl_low | output | CNT_W | SCL low count |
| scl_high | output | CNT_W | SCL high count |
| sda_hold | output | CNT_W | SDA hold count |
| irq | output | 1 | Level interrupt |

## Verification
Two collisions are provoked on purpose. In the first, a write-1-to-clear of the arbitration flag falls in the same clock edge as a fresh `eng_arb` pulse. The bit is then read back and must still be set. In the second, the engine pushes a byte in the same cycle that software reads a full receive queue. The bench judges this by the absence of the overflow flag, an unchanged level of FIFO_DEPTH, and the drained byte order, with the new byte last. The threshold flags and the interrupt are swept over every level, threshold code and enable mask, and the results are compared with values computed in the bench.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;

  localparam int ADDR_W = 6;
  localparam int CMD_W  = 10;
  localparam int IRQ_N  = 5;

  localparam logic [ADDR_W-1:0] OFS_CMD = 6'h00;
  localparam logic [ADDR_W-1:0] OFS_RXD = 6'h04;
  localparam logic [ADDR_W-1:0] OFS_CTL = 6'h08;
  localparam logic [ADDR_W-1:0] OFS_IEN = 6'h0C;
  localparam logic [ADDR_W-1:0] OFS_IST = 6'h10;
  localparam logic [ADDR_W-1:0] OFS_STA = 6'h14;
  localparam logic [ADDR_W-1:0] OFS_CLV = 6'h18;
  localparam logic [ADDR_W-1:0] OFS_RLV = 6'h1C;
  localparam logic [ADDR_W-1:0] OFS_SLO = 6'h20;
  localparam logic [ADDR_W-1:0] OFS_SHI = 6'h24;
  localparam logic [ADDR_W-1:0] OFS_HLD = 6'h28;

  // control word, enable in bit 0
  typedef struct packed {
    logic [1:0] rx_thr;
    logic [1:0] cmd_thr;
    logic       fast;
    logic       en;
  } ctrl_t;

  // ready while the queue holds no more than the threshold code
  function automatic logic tx_ready_f(input logic [31:0] lvl, input logic [1:0] code);
    return lvl <= {30'd0, code};
  endfunction

  // ready once the queue holds more than the threshold code
  function automatic logic rx_ready_f(input logic [31:0] lvl, input logic [1:0] code);
    return lvl > {30'd0, code};
  endfunction

endpackage

// File: rtl/i2cm_fifo.sv
module i2cm_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         flush,
  input  logic                         push,
  input  logic [W-1:0]                 din,
  input  logic                         pop,
  output logic [W-1:0]                 dout,
  output logic [$clog2(DEPTH+1)-1:0]   lvl,
  output logic                         full,
  output logic                         empty,
  output logic                         drop
);
  localparam int PW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int LVL_W = $clog2(DEPTH+1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic          pop_ok, push_ok;

  function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
    return (p == PW'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (lvl == LVL_W'(DEPTH));
  assign empty   = (lvl == '0);
  assign pop_ok  = pop && !empty;
  assign push_ok = push && (!full || pop_ok);
  assign drop    = push && !push_ok;
  assign dout    = mem[rp];

  always_ff @(posedge clk) begin
    if (push_ok && !flush) mem[wp] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      lvl <= '0;
    end else if (flush) begin
      wp  <= '0;
      rp  <= '0;
      lvl <= '0;
    end else begin
      if (push_ok) wp <= step(wp);
      if (pop_ok)  rp <= step(rp);
      unique case ({push_ok, pop_ok})
        2'b10:   lvl <= lvl + LVL_W'(1);
        2'b01:   lvl <= lvl - LVL_W'(1);
        default: lvl <= lvl;
      endcase
    end
  end

  p_lvl_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    lvl <= LVL_W'(DEPTH));
  p_full_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush && full && push && !pop) |=> full);
  p_pop_empty_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush && empty && pop && !push) |=> empty);

endmodule

// File: rtl/i2cm_irq.sv
module i2cm_irq
  import i2cm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             ev_nack,
  input  logic             ev_arb,
  input  logic             ev_ovf,
  input  logic [2:0]       clr_mask,
  input  logic             tx_rdy,
  input  logic             rx_rdy,
  input  logic [IRQ_N-1:0] ien,
  output logic [IRQ_N-1:0] ist,
  output logic             irq
);
  // sticky[0] nack, sticky[1] arbitration lost, sticky[2] receive overflow
  logic [2:0] sticky;
  logic [2:0] set_v;

  assign set_v = en ? {ev_ovf, ev_arb, ev_nack} : 3'b000;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   sticky <= '0;
    else if (!en) sticky <= '0;
    else          sticky <= (sticky & ~clr_mask) | set_v;
  end

  assign ist = {sticky, rx_rdy, tx_rdy};
  assign irq = |(ist & ien);

  p_event_sets_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (en && ev_nack) |=> ist[2]);
  p_event_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (en && ev_arb && clr_mask[1]) |=> ist[3]);
  p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (en && clr_mask[0] && !ev_nack) |=> !ist[2]);
  p_off_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (ist[4:2] == 3'b000));
  p_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ien == '0) |-> !irq);

endmodule

// File: rtl/i2cm_regfront.sv
module i2cm_regfront
  import i2cm_pkg::*;
#(
  parameter int FIFO_DEPTH = 4,
  parameter int CNT_W      = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [5:0]        bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              cmd_valid,
  output logic [9:0]        cmd_word,
  input  logic              cmd_take,
  input  logic              rx_push,
  input  logic [7:0]        rx_byte,
  input  logic              eng_nack,
  input  logic              eng_arb,
  input  logic              eng_busy,
  output logic              core_en,
  output logic              fast_mode,
  output logic [CNT_W-1:0]  scl_low,
  output logic [CNT_W-1:0]  scl_high,
  output logic [CNT_W-1:0]  sda_hold,
  output logic              irq
);
  localparam int LVL_W = $clog2(FIFO_DEPTH+1);

  ctrl_t             ctl;
  logic [IRQ_N-1:0]  ien;
  logic [IRQ_N-1:0]  ist;

  // decoded bus events
  logic wr_cmd, wr_ctl, wr_ien, wr_ist, wr_slo, wr_shi, wr_hld, rd_rxd;
  assign wr_cmd = bus_wr && (bus_addr == OFS_CMD);
  assign wr_ctl = bus_wr && (bus_addr == OFS_CTL);
  assign wr_ien = bus_wr && (bus_addr == OFS_IEN);
  assign wr_ist = bus_wr && (bus_addr == OFS_IST);
  assign wr_slo = bus_wr && (bus_addr == OFS_SLO);
  assign wr_shi = bus_wr && (bus_addr == OFS_SHI);
  assign wr_hld = bus_wr && (bus_addr == OFS_HLD);
  assign rd_rxd = bus_rd && (bus_addr == OFS_RXD);

  logic unused_wdata;
  assign unused_wdata = ^bus_wdata;

  // queue handshakes
  logic             flush;
  logic             cmd_push, rx_in, rx_pop;
  logic [LVL_W-1:0] cmd_lvl, rx_lvl;
  logic             cmd_full, cmd_empty, cmd_drop;
  logic             rx_full, rx_empty, rx_drop;
  logic [7:0]       rx_head;
  logic [CMD_W-1:0] cmd_head;

  assign flush    = !ctl.en;
  assign cmd_push = wr_cmd && ctl.en;
  assign rx_in    = rx_push && ctl.en;
  assign rx_pop   = rd_rxd && ctl.en;

  i2cm_fifo #(.W(CMD_W), .DEPTH(FIFO_DEPTH)) u_cmdq (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .push(cmd_push), .din(bus_wdata[CMD_W-1:0]),
    .pop(cmd_take), .dout(cmd_head), .lvl(cmd_lvl),
    .full(cmd_full), .empty(cmd_empty), .drop(cmd_drop)
  );

  i2cm_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .push(rx_in), .din(rx_byte),
    .pop(rx_pop), .dout(rx_head), .lvl(rx_lvl),
    .full(rx_full), .empty(rx_empty), .drop(rx_drop)
  );

  assign cmd_valid = ctl.en && !cmd_empty;
  assign cmd_word  = cmd_head;

  // threshold flags
  logic tx_rdy, rx_rdy;
  assign tx_rdy = tx_ready_f(32'(cmd_lvl), ctl.cmd_thr);
  assign rx_rdy = rx_ready_f(32'(rx_lvl),  ctl.rx_thr);

  i2cm_irq u_irq (
    .clk(clk), .rst_n(rst_n), .en(ctl.en),
    .ev_nack(eng_nack), .ev_arb(eng_arb), .ev_ovf(rx_drop),
    .clr_mask(wr_ist ? bus_wdata[4:2] : 3'b000),
    .tx_rdy(tx_rdy), .rx_rdy(rx_rdy),
    .ien(ien), .ist(ist), .irq(irq)
  );

  // configuration registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl      <= '0;
      ien      <= '0;
      scl_low  <= '0;
      scl_high <= '0;
      sda_hold <= '0;
    end else begin
      if (wr_ctl) ctl      <= ctrl_t'(bus_wdata[5:0]);
      if (wr_ien) ien      <= bus_wdata[IRQ_N-1:0];
      if (wr_slo) scl_low  <= bus_wdata[CNT_W-1:0];
      if (wr_shi) scl_high <= bus_wdata[CNT_W-1:0];
      if (wr_hld) sda_hold <= bus_wdata[CNT_W-1:0];
    end
  end

  assign core_en   = ctl.en;
  assign fast_mode = ctl.fast;

  // read multiplexer
  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      OFS_RXD: bus_rdata = rx_empty ? 32'd0 : 32'(rx_head);
      OFS_CTL: bus_rdata = 32'(ctl);
      OFS_IEN: bus_rdata = 32'(ien);
      OFS_IST: bus_rdata = 32'(ist);
      OFS_STA: bus_rdata = {31'd0, eng_busy};
      OFS_CLV: bus_rdata = 32'(cmd_lvl);
      OFS_RLV: bus_rdata = 32'(rx_lvl);
      OFS_SLO: bus_rdata = 32'(scl_low);
      OFS_SHI: bus_rdata = 32'(scl_high);
      OFS_HLD: bus_rdata = 32'(sda_hold);
      default: bus_rdata = '0;
    endcase
  end

  p_disabled_flush_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl.en |=> (cmd_lvl == '0) && (rx_lvl == '0));
  p_cmd_take_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_take && !cmd_push) |=> (cmd_lvl == $past(cmd_lvl) - LVL_W'(1)));
  p_cmd_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_drop |-> (cmd_full && !cmd_take));
  p_ovf_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_in && rx_full && !rx_pop) |=> ist[4]);

endmodule

// File: tb/sim_i2cm_regfront.sv
module sim_i2cm_regfront;
  localparam int DEPTH = 4;
  localparam int CW    = 16;

  localparam logic [5:0] A_CMD = 6'h00, A_RXD = 6'h04, A_CTL = 6'h08, A_IEN = 6'h0C,
                         A_IST = 6'h10, A_STA = 6'h14, A_CLV = 6'h18, A_RLV = 6'h1C,
                         A_SLO = 6'h20, A_SHI = 6'h24, A_HLD = 6'h28;

  logic clk = 0, rst_n = 0;
  logic bus_wr = 0, bus_rd = 0;
  logic [5:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic cmd_valid, cmd_take = 0;
  logic [9:0] cmd_word;
  logic rx_push = 0;
  logic [7:0] rx_byte = 0;
  logic eng_nack = 0, eng_arb = 0, eng_busy = 0;
  logic core_en, fast_mode, irq;
  logic [CW-1:0] scl_low, scl_high, sda_hold;

  int nvec = 0, nbad = 0;

  always #2 clk = ~clk;

  i2cm_regfront #(.FIFO_DEPTH(DEPTH), .CNT_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
    .cmd_take(cmd_take), .rx_push(rx_push), .rx_byte(rx_byte), .eng_nack(eng_nack),
    .eng_arb(eng_arb), .eng_busy(eng_busy), .core_en(core_en), .fast_mode(fast_mode),
    .scl_low(scl_low), .scl_high(scl_high), .sda_hold(sda_hold), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = (a == A_RXD);
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 0;
  endtask

  task automatic push_rx(input logic [7:0] b);
    @(negedge clk);
    rx_push = 1; rx_byte = b;
    @(negedge clk);
    rx_push = 0;
  endtask

  task automatic take();
    @(negedge clk);
    cmd_take = 1;
    @(negedge clk);
    cmd_take = 0;
  endtask

  task automatic pulse_nack();
    @(negedge clk); eng_nack = 1;
    @(negedge clk); eng_nack = 0;
  endtask

  task automatic pulse_arb();
    @(negedge clk); eng_arb = 1;
    @(negedge clk); eng_arb = 0;
  endtask

  task automatic reenable(input logic [31:0] ctl);
    wr(A_CTL, 0);
    wr(A_CTL, ctl);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nbad++;
    $display("FAIL watchdog: got hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic [9:0] cmds [4];
    cmds[0] = 10'h2A5; cmds[1] = 10'h0F0; cmds[2] = 10'h1C3; cmds[3] = 10'h07E;

    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    rd(A_CTL, v); chk("R1 ctrl", v, 0);
    rd(A_IEN, v); chk("R1 ien", v, 0);
    rd(A_CLV, v); chk("R1 cmd lvl", v, 0);
    rd(A_RLV, v); chk("R1 rx lvl", v, 0);
    rd(A_IST, v); chk("R1 status", v, 32'h1);
    rd(A_SLO, v); chk("R1 scl low", v, 0);
    chk("R1 irq", {31'd0, irq}, 0);
    chk("R1 cmd_valid", {31'd0, cmd_valid}, 0);

    // R11 commands ignored while disabled
    wr(A_CMD, 32'h2A5);
    rd(A_CLV, v); chk("R11 cmd while off", v, 0);
    push_rx(8'h5A);
    rd(A_RLV, v); chk("R11 rx while off", v, 0);

    // R6 control
    wr(A_CTL, 32'h3A);
    rd(A_CTL, v); chk("R6 ctrl readback", v, 32'h3A);
    chk("R6 fast", {31'd0, fast_mode}, 1);
    chk("R6 en off", {31'd0, core_en}, 0);
    wr(A_CTL, 32'h1);
    chk("R6 en on", {31'd0, core_en}, 1);
    chk("R6 slow", {31'd0, fast_mode}, 0);

    // R2 / R3 command queue
    for (int i = 0; i < 4; i++) begin
      wr(A_CMD, 32'hFFFF_FC00 | 32'(cmds[i]));
      rd(A_CLV, v); chk("R2 cmd lvl", v, 32'(i + 1));
    end
    wr(A_CMD, 32'h3FF);
    rd(A_CLV, v); chk("R3 full drop lvl", v, DEPTH);
    for (int i = 0; i < 4; i++) begin
      #1;
      chk("R2 valid", {31'd0, cmd_valid}, 1);
      chk("R2 word order", {22'd0, cmd_word}, {22'd0, cmds[i]});
      take();
    end
    #1 chk("R2 drained", {31'd0, cmd_valid}, 0);

    // R7 TX ready sweep
    for (int t = 0; t < 4; t++) begin
      reenable(32'h1 | (t << 2));
      for (int n = 0; n <= DEPTH; n++) begin
        rd(A_IST, v); chk("R7 tx ready", {31'd0, v[0]}, {31'd0, (t - n) >= 0});
        if (n < DEPTH) wr(A_CMD, 32'(n));
      end
    end
    reenable(32'h1);
    rd(A_CLV, v); chk("R11 cmd flushed", v, 0);

    // R7 RX ready sweep
    for (int t = 0; t < 4; t++) begin
      reenable(32'h1 | (t << 4));
      for (int n = 0; n <= DEPTH; n++) begin
        rd(A_IST, v); chk("R7 rx ready", {31'd0, v[1]}, {31'd0, (n - t) > 0});
        rd(A_RLV, v); chk("R4 rx lvl", v, 32'(n));
        if (n < DEPTH) push_rx(8'(n));
      end
    end
    reenable(32'h1);
    rd(A_RLV, v); chk("R11 rx flushed", v, 0);

    // R4 receive order and empty read
    push_rx(8'h11); push_rx(8'h22); push_rx(8'h33);
    rd(A_RXD, v); chk("R4 first", v, 32'h11);
    rd(A_RLV, v); chk("R4 lvl after pop", v, 2);
    rd(A_RXD, v); chk("R4 second", v, 32'h22);
    rd(A_RXD, v); chk("R4 third", v, 32'h33);
    rd(A_RXD, v); chk("R4 empty read", v, 0);
    rd(A_RLV, v); chk("R4 empty lvl", v, 0);

    // R5 overflow
    for (int i = 0; i < 4; i++) push_rx(8'h40 + 8'(i));
    rd(A_IST, v); chk("R5 no ovf yet", {31'd0, v[4]}, 0);
    push_rx(8'h99);
    rd(A_IST, v); chk("R5 ovf set", {31'd0, v[4]}, 1);
    rd(A_RLV, v); chk("R5 lvl", v, DEPTH);
    for (int i = 0; i < 4; i++) begin
      rd(A_RXD, v); chk("R5 kept bytes", v, 32'h40 + 32'(i));
    end
    wr(A_IST, 32'h10);
    rd(A_IST, v); chk("R9 ovf cleared", {31'd0, v[4]}, 0);

    // R5 push during read of full queue
    for (int i = 0; i < 4; i++) push_rx(8'hA0 + 8'(i));
    @(negedge clk);
    rx_push = 1; rx_byte = 8'hB0; bus_addr = A_RXD; bus_rd = 1;
    #1 chk("R5 simultaneous head", bus_rdata, 32'hA0);
    @(negedge clk);
    rx_push = 0; bus_rd = 0;
    rd(A_IST, v); chk("R5 no ovf on simultaneous", {31'd0, v[4]}, 0);
    rd(A_RLV, v); chk("R5 lvl stays full", v, DEPTH);
    for (int i = 1; i < 4; i++) begin
      rd(A_RXD, v); chk("R5 order", v, 32'hA0 + 32'(i));
    end
    rd(A_RXD, v); chk("R5 new byte last", v, 32'hB0);

    // R8 / R9 sticky flags
    pulse_nack();
    rd(A_IST, v); chk("R8 nack", v[4:2], 3'b001);
    pulse_arb();
    rd(A_IST, v); chk("R8 arb", v[4:2], 3'b011);
    wr(A_IST, 32'h4);
    rd(A_IST, v); chk("R9 partial clear", v[4:2], 3'b010);
    @(negedge clk);
    bus_wr = 1; bus_addr = A_IST; bus_wdata = 32'h8; eng_arb = 1;
    @(negedge clk);
    bus_wr = 0; eng_arb = 0;
    rd(A_IST, v); chk("R9 event beats clear", v[4:2], 3'b010);
    wr(A_IST, 32'h1F);
    rd(A_IST, v); chk("R9 full clear keeps live bits", v, 32'h1);

    // R10 interrupt enable sweep, status = nack + tx ready
    pulse_nack();
    for (int i = 0; i < 32; i++) begin
      wr(A_IEN, 32'(i));
      #1 chk("R10 irq", {31'd0, irq}, {31'd0, (i % 2 == 1) || ((i / 4) % 2 == 1)});
    end
    rd(A_IEN, v); chk("R10 ien readback", v, 32'h1F);
    wr(A_IEN, 0);

    // R11 disable clears flags and ignores events
    wr(A_CTL, 0);
    pulse_nack(); pulse_arb();
    wr(A_CTL, 1);
    rd(A_IST, v); chk("R11 sticky cleared", v[4:2], 3'b000);

    // R12 timing counts
    wr(A_SLO, 32'hFFFF_1234);
    wr(A_SHI, 32'h0000_0ABC);
    wr(A_HLD, 32'h0005_001E);
    rd(A_SLO, v); chk("R12 low rb", v, 32'h1234);
    rd(A_SHI, v); chk("R12 high rb", v, 32'h0ABC);
    rd(A_HLD, v); chk("R12 hold rb", v, 32'h001E);
    chk("R12 low out", 32'(scl_low), 32'h1234);
    chk("R12 hold out", 32'(sda_hold), 32'h001E);

    // R13 status and unmapped reads
    eng_busy = 1;
    rd(A_STA, v); chk("R13 busy", v, 1);
    eng_busy = 0;
    rd(A_STA, v); chk("R13 idle", v, 0);
    rd(6'h2C, v); chk("R13 unmapped", v, 0);
    wr(A_CMD, 32'h155);
    rd(A_CMD, v); chk("R13 cmd offset reads 0", v, 0);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule